// File: doc/BRIEF.md
# Self-Starting Five-Code Sequence Counter

This block is a free-running 3-bit synchronous counter. It steps through a fixed loop of five codes that do not follow binary order, and it moves on every rising clock edge. The count output is the state register itself, with no decode between the flip-flops and the pins. The bits are named C, B and A, from most to least significant.

Three of the eight codes are outside the loop. Each of them has a defined successor rather than a don't-care, so a register that powers up in one of them, or is pushed into one, rejoins the loop within two clocks. A debug load port can write any code into the state register, which lets the recovery paths be exercised on purpose. A flag output goes high while the register holds one of the three unused codes.

The block has only plain control and status pins and no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `fivecode_counter`

## Requirements
- R1: While `rst` is high at a rising edge, `count` becomes 000 after that edge, even if `dbg_load` is also high.
- R2: With `rst` and `dbg_load` low, each edge moves `count` along the legal loop 000 → 010 → 011 → 101 → 110 → 000 (values written as C B A, bit 2 = C, bit 0 = A).
- R3: With `rst` and `dbg_load` low, unused code 001 is followed by 110.
- R4: With `rst` and `dbg_load` low, unused code 100 is followed by 010.
- R5: With `rst` and `dbg_load` low, unused code 111 is followed by 100 and then by 010.
- R6: With `rst` low and `dbg_load` high at an edge, `count` takes the value of `dbg_code` after that edge, in place of the normal successor.
- R7: `off_loop` is high exactly while `count` is 001, 100 or 111, and low for the five legal codes.
- R8: From any of the eight codes, with `rst` and `dbg_load` low, `count` holds a legal code after at most two edges and stays in the loop after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to 000 |
| dbg_load | input | 1 | Writes `dbg_code` into the state register at the next edge |
| dbg_code | input | 3 | Code written by the debug load |
| count | output | 3 | State register {C,B,A} |
| off_loop | output | 1 | High while the state is an unused code |

## Verification
The bench loads each unused code and follows it until it is back in the loop. A design that treated those codes as don't-cares would sit in a two-code side loop or fail to return within two clocks, and the checks after the second edge would catch it. It also runs the whole loop from reset and from a mid-loop load, so a swapped or skipped successor shows up as a wrong code at that step. Reset is asserted together with a load to check that reset wins, and `off_loop` is compared on every code, which would expose a flag that missed one code or marked a legal code as unused.

// File: rtl/fivecode_pkg.sv
package fivecode_pkg;
  localparam int STATE_W   = 3;
  localparam int LOOP_LEN  = 5;
  localparam int NUM_CODES = 1 << STATE_W;

  // bit positions of the state vector
  localparam int BIT_C = 2;
  localparam int BIT_B = 1;
  localparam int BIT_A = 0;

  typedef logic [STATE_W-1:0] code_t;

  localparam code_t RESET_CODE = 3'b000;

  localparam code_t LOOP_CODES [LOOP_LEN] = '{
    3'b000, 3'b010, 3'b011, 3'b101, 3'b110
  };
endpackage

// File: rtl/fivecode_next.sv
module fivecode_next
  import fivecode_pkg::*;
(
  input  code_t cur,
  output code_t nxt
);
  logic c_q, b_q, a_q;

  always_comb begin
    c_q = cur[BIT_C];
    b_q = cur[BIT_B];
    a_q = cur[BIT_A];
    nxt = '0;
    // the unused codes get fixed successors through these equations
    nxt[BIT_C] = a_q;
    nxt[BIT_B] = ~b_q | (~a_q & ~c_q);
    nxt[BIT_A] = b_q & ~c_q;
  end
endmodule

// File: rtl/fivecode_loopdet.sv
module fivecode_loopdet
  import fivecode_pkg::*;
(
  input  code_t cur,
  output logic  off_loop
);
  logic [LOOP_LEN-1:0] hit;

  for (genvar g = 0; g < LOOP_LEN; g++) begin : g_match
    assign hit[g] = (cur == LOOP_CODES[g]);
  end

  assign off_loop = ~(|hit);
endmodule

// File: rtl/fivecode_counter.sv
module fivecode_counter
  import fivecode_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               dbg_load,
  input  logic [STATE_W-1:0] dbg_code,
  output logic [STATE_W-1:0] count,
  output logic               off_loop
);
  code_t state_q;
  code_t succ;

  fivecode_next u_next (
    .cur (state_q),
    .nxt (succ)
  );

  fivecode_loopdet u_det (
    .cur      (state_q),
    .off_loop (off_loop)
  );

  always_ff @(posedge clk) begin
    if (rst)           state_q <= RESET_CODE;
    else if (dbg_load) state_q <= dbg_code;
    else               state_q <= succ;
  end

  assign count = state_q;
endmodule

// File: rtl/fivecode_counter_chk.sv
module fivecode_counter_chk
  import fivecode_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               dbg_load,
  input logic [STATE_W-1:0] dbg_code,
  input logic [STATE_W-1:0] count,
  input logic               off_loop
);
  logic run;
  assign run = !rst && !dbg_load;

  // R1: reset wins over everything
  p_reset_r1: assert property (@(posedge clk) rst |=> count == 3'b000);

  // R6: debug load
  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    dbg_load |=> count == $past(dbg_code));

  // R2: legal loop order
  p_step0_r2: assert property (@(posedge clk) disable iff (rst)
    (run && count == 3'b000) |=> count == 3'b010);
  p_step1_r2: assert property (@(posedge clk) disable iff (rst)
    (run && count == 3'b010) |=> count == 3'b011);
  p_step2_r2: assert property (@(posedge clk) disable iff (rst)
    (run && count == 3'b011) |=> count == 3'b101);
  p_step3_r2: assert property (@(posedge clk) disable iff (rst)
    (run && count == 3'b101) |=> count == 3'b110);
  p_step4_r2: assert property (@(posedge clk) disable iff (rst)
    (run && count == 3'b110) |=> count == 3'b000);

  // R3, R4, R5: recovery paths
  p_rec001_r3: assert property (@(posedge clk) disable iff (rst)
    (run && count == 3'b001) |=> count == 3'b110);
  p_rec100_r4: assert property (@(posedge clk) disable iff (rst)
    (run && count == 3'b100) |=> count == 3'b010);
  p_rec111_r5: assert property (@(posedge clk) disable iff (rst)
    (run && count == 3'b111) |=> count == 3'b100);

  // R8: a legal code never leads out of the loop
  p_stay_r8: assert property (@(posedge clk) disable iff (rst)
    (run && !off_loop) |=> !off_loop);

  // R7: flag tracks the unused codes
  p_flag_r7: assert property (@(posedge clk) disable iff (rst)
    off_loop == (count == 3'b001 || count == 3'b100 || count == 3'b111));
endmodule

bind fivecode_counter fivecode_counter_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .dbg_load (dbg_load),
  .dbg_code (dbg_code),
  .count    (count),
  .off_loop (off_loop)
);

// File: tb/fivecode_counter_bench.sv
module fivecode_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dbg_load = 1'b0;
  logic [2:0] dbg_code = 3'b000;
  logic [2:0] count;
  logic       off_loop;

  int checks = 0;
  int fails  = 0;

  fivecode_counter u_fivecode_counter (
    .clk      (clk),
    .rst      (rst),
    .dbg_load (dbg_load),
    .dbg_code (dbg_code),
    .count    (count),
    .off_loop (off_loop)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // vector: [12:9] requirement, [8] rst, [7] load, [6:4] code, [3:1] expected count, [0] expected flag
  localparam logic [12:0] VEC [NVEC] = '{
    {4'd1, 1'b1, 1'b0, 3'b000, 3'b000, 1'b0}, // R1 reset
    {4'd2, 1'b0, 1'b0, 3'b000, 3'b010, 1'b0}, // R2
    {4'd2, 1'b0, 1'b0, 3'b000, 3'b011, 1'b0}, // R2
    {4'd2, 1'b0, 1'b0, 3'b000, 3'b101, 1'b0}, // R2
    {4'd2, 1'b0, 1'b0, 3'b000, 3'b110, 1'b0}, // R2
    {4'd2, 1'b0, 1'b0, 3'b000, 3'b000, 1'b0}, // R2 wrap
    {4'd2, 1'b0, 1'b0, 3'b000, 3'b010, 1'b0}, // R2
    {4'd6, 1'b0, 1'b1, 3'b001, 3'b001, 1'b1}, // R6 load, R7 flag
    {4'd3, 1'b0, 1'b0, 3'b000, 3'b110, 1'b0}, // R3
    {4'd6, 1'b0, 1'b1, 3'b100, 3'b100, 1'b1}, // R6, R7
    {4'd4, 1'b0, 1'b0, 3'b000, 3'b010, 1'b0}, // R4
    {4'd6, 1'b0, 1'b1, 3'b111, 3'b111, 1'b1}, // R6, R7
    {4'd5, 1'b0, 1'b0, 3'b000, 3'b100, 1'b1}, // R5 first step
    {4'd5, 1'b0, 1'b0, 3'b000, 3'b010, 1'b0}, // R5 second step
    {4'd1, 1'b1, 1'b1, 3'b111, 3'b000, 1'b0}, // R1 reset beats load
    {4'd6, 1'b0, 1'b1, 3'b101, 3'b101, 1'b0}, // R6 legal load
    {4'd2, 1'b0, 1'b0, 3'b000, 3'b110, 1'b0}, // R2
    {4'd1, 1'b1, 1'b0, 3'b000, 3'b000, 1'b0}  // R1
  };

  function automatic logic is_unused(input logic [2:0] c);
    return (c == 3'b001) || (c == 3'b100) || (c == 3'b111);
  endfunction

  task automatic check(input string req, input logic [2:0] exp_c, input logic exp_f);
    checks++;
    if (count !== exp_c || off_loop !== exp_f) begin
      fails++;
      $display("FAIL %s count=%b off_loop=%b expected count=%b off_loop=%b",
               req, count, off_loop, exp_c, exp_f);
    end
  endtask

  task automatic cycle(input logic r, input logic ld, input logic [2:0] code);
    @(negedge clk);
    rst = r; dbg_load = ld; dbg_code = code;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  initial begin
    #(CLK_PERIOD*2000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // table walk
    for (int i = 0; i < NVEC; i++) begin
      cycle(VEC[i][8], VEC[i][7], VEC[i][6:4]);
      check($sformatf("R%0d vec%0d", VEC[i][12:9], i), VEC[i][3:1], VEC[i][0]);
    end

    // R8: from every code, in the loop after two edges and staying there
    for (int c = 0; c < 8; c++) begin
      cycle(1'b0, 1'b1, 3'(c));
      check("R7 loaded code flag", 3'(c), is_unused(3'(c)));
      cycle(1'b0, 1'b0, 3'b000);
      cycle(1'b0, 1'b0, 3'b000);
      checks++;
      if (off_loop !== 1'b0 || is_unused(count)) begin
        fails++;
        $display("FAIL R8 start=%b count=%b off_loop=%b expected a legal code, off_loop=0",
                 3'(c), count, off_loop);
      end
      for (int k = 0; k < 6; k++) begin
        cycle(1'b0, 1'b0, 3'b000);
        checks++;
        if (off_loop !== 1'b0) begin
          fails++;
          $display("FAIL R8 left loop start=%b count=%b expected off_loop=0", 3'(c), count);
        end
      end
    end

    // R1: reset in the middle of the loop
    cycle(1'b1, 1'b0, 3'b000);
    check("R1 mid-run reset", 3'b000, 1'b0);
    cycle(1'b0, 1'b0, 3'b000);
    check("R2 after reset", 3'b010, 1'b0);

    // R2: a longer free run compared against the loop order
    begin
      logic [2:0] order [5];
      order[0] = 3'b000; order[1] = 3'b010; order[2] = 3'b011;
      order[3] = 3'b101; order[4] = 3'b110;
      for (int n = 0; n < 15; n++) begin
        cycle(1'b0, 1'b0, 3'b000);
        check("R2 free run", order[(n + 2) % 5], 1'b0);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule